// File: doc/BRIEF.md
# Power-of-two system clock divider with reference loss supervisor

This block turns the output of a PLL into the system clock by passing one PLL pulse out of every 2^N, where N is a 3-bit divide code held in a small control register. A new code is accepted only while the PLL reports lock. It takes effect when the system clock period in progress ends, at the falling edge of the pulse that closes that period. A clock enable latch that is transparent in the low phase of the PLL clock gates the output, so a ratio change can never cut a pulse short. A second output, the pin clock, copies the system clock unless a disable bit forces it low.

The block also watches a reference clock from a free-running backup clock. Reference levels pass through a synchronizer into the backup domain. If no reference edge is seen for a set number of backup cycles, a sticky loss flag rises. A reset request goes to the external reset controller when three conditions hold: the flag is set, the supervisor is enabled, and the reset-enable bit is set. An external-clock-mode strap disables all of this.

Top module: `clkdiv_loc_top`

## Requirements
- R1: After reset the divide code is 0, so the system clock pulses on every PLL cycle. The supervisor enable, the reset enable and the pin-clock disable bits are all 0, and loss_flag and reset_req are both low.
- R2: With divide code N (0 to 7), the system clock gives exactly one high pulse every 2^N PLL cycles. Each pulse is the high phase of one PLL cycle.
- R3: A new divide code written during a system clock period does not shorten or stretch that period. The first period that starts after the closing pulse uses the new ratio.
- R4: When a write arrives while pll_locked is low, the divide field keeps its old value. The other three bits in the same write are still stored.
- R5: While the pin-clock disable bit is 1, clkout stays low. While it is 0, clkout equals sys_clk.
- R6: While the supervisor enable bit is 0, no loss is detected and reset_req stays low, whatever the reset-enable bit holds.
- R7: With the supervisor enabled, loss_flag rises once the synchronized reference has shown no edge for 16 consecutive backup cycles. It stays low while the reference keeps toggling. Once set, it stays set until reset, even after the reference comes back.
- R8: reset_req is high when loss_flag, the supervisor enable and the reset enable are all 1. Setting the reset enable while the flag is already set raises reset_req in the same PLL cycle as the write.
- R9: While ext_mode is high, loss_flag is not set and reset_req stays low, whatever the two enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | PLL output clock; clocks the control register and the divider |
| bkp_clk | input | 1 | Free-running backup clock for the supervisor |
| ref_clk | input | 1 | Reference clock that is supervised |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| pll_locked | input | 1 | PLL lock indication; gates writes to the divide field |
| ext_mode | input | 1 | External-clock-mode strap; disables loss supervision and its reset |
| wr_en | input | 1 | Control register write strobe (pll_clk domain) |
| wr_div | input | 3 | Divide code N; ratio 2^N |
| wr_loc_en | input | 1 | Supervisor enable value |
| wr_rst_en | input | 1 | Reset-on-loss enable value |
| wr_out_dis | input | 1 | Pin-clock disable value (1 holds clkout low) |
| sys_clk | output | 1 | Divided system clock |
| clkout | output | 1 | Pin copy of sys_clk, or low when disabled |
| loss_flag | output | 1 | Sticky loss-of-reference flag |
| reset_req | output | 1 | Reset request to the external reset controller |

## Verification
A wrong divider counter or a wrong applied code shows as a wrong spacing between sys_clk pulses. The bench sees it within one period of the selected ratio, at most 128 PLL cycles. A code applied too early or too late shows up in the single period that spans a write, so the bench times that period against the remaining cycles of the old ratio. A wrong supervisor count or a broken synchronizer shows on loss_flag about 20 backup cycles after the reference stops, or as a false flag while the reference runs. Faulty enable gating shows on reset_req in the cycle after the control write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DIV_W = 3;
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  typedef logic [DIV_W-1:0] div_code_t;

  typedef struct packed {
    div_code_t div;
    logic      loc_en;
    logic      rst_en;
    logic      out_dis;
  } ctl_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  div_code_t pend_code,
  output logic      sys_clk,
  output logic [CNT_W-1:0] cnt_o,
  output div_code_t act_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  div_code_t        act_q, act_d;
  logic             gate_en, gate_lat;

  function automatic logic [CNT_W-1:0] wrap_of(input div_code_t c);
    logic [CNT_W:0] t;
    t = (CNT_W+1)'(1) << c;
    t = t - (CNT_W+1)'(1);
    return t[CNT_W-1:0];
  endfunction

  // a period ends on the pulse cycle (cnt 0); the pending code is taken there
  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (cnt_q == '0) begin
      act_d = pend_code;
      cnt_d = (wrap_of(pend_code) == '0) ? '0 : CNT_W'(1);
    end else if (cnt_q == wrap_of(act_q)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign gate_en = (cnt_q == '0);

  // enable latch open only in the low phase: no runt pulses
  always_latch begin
    if (!clk) gate_lat = gate_en;
  end

  assign sys_clk = clk & gate_lat;
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;
endmodule

// File: rtl/clkdiv_loc_det.sv
module clkdiv_loc_det #(
  parameter int unsigned WINDOW = 16,
  parameter int unsigned SYNC   = 2
) (
  input  logic bkp_clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic enable,
  output logic flag
);
  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic [SYNC:0]   ref_sh;
  logic [SYNC-1:0] en_sh;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            flag_q, flag_d;
  logic            en_s, edge_seen;

  always_ff @(posedge bkp_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      en_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[SYNC-1:0], ref_clk};
      en_sh  <= {en_sh[SYNC-2:0], enable};
    end
  end

  assign en_s      = en_sh[SYNC-1];
  assign edge_seen = ref_sh[SYNC] ^ ref_sh[SYNC-1];

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (!en_s || edge_seen)        cnt_d = '0;
    else if (cnt_q != CW'(WINDOW)) cnt_d = cnt_q + CW'(1);
    if (en_s && cnt_q == CW'(WINDOW)) flag_d = 1'b1;
  end

  always_ff @(posedge bkp_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/clkdiv_loc_top.sv
module clkdiv_loc_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned LOC_WINDOW  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       pll_clk,
  input  logic       bkp_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pll_locked,
  input  logic       ext_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_div,
  input  logic       wr_loc_en,
  input  logic       wr_rst_en,
  input  logic       wr_out_dis,
  output logic       sys_clk,
  output logic       clkout,
  output logic       loss_flag,
  output logic       reset_req
);
  logic             pll_rst_n, bkp_rst_n;
  ctl_t             ctl_q, ctl_d;
  div_code_t        pend_div, div_act;
  logic [CNT_W-1:0] div_cnt;
  logic             loc_en_q, rst_en_q, out_dis_q;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_pll (
    .clk(pll_clk), .arst_n(rst_n), .rst_n_o(pll_rst_n));
  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_bkp (
    .clk(bkp_clk), .arst_n(rst_n), .rst_n_o(bkp_rst_n));

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.loc_en  = wr_loc_en;
      ctl_d.rst_en  = wr_rst_en;
      ctl_d.out_dis = wr_out_dis;
      if (pll_locked) ctl_d.div = wr_div;
    end
  end

  always_ff @(posedge pll_clk or negedge pll_rst_n) begin
    if (!pll_rst_n) ctl_q <= '0;
    else            ctl_q <= ctl_d;
  end

  assign pend_div  = ctl_q.div;
  assign loc_en_q  = ctl_q.loc_en;
  assign rst_en_q  = ctl_q.rst_en;
  assign out_dis_q = ctl_q.out_dis;

  clkdiv_gate u_div (
    .clk      (pll_clk),
    .rst_n    (pll_rst_n),
    .pend_code(pend_div),
    .sys_clk  (sys_clk),
    .cnt_o    (div_cnt),
    .act_o    (div_act)
  );

  clkdiv_loc_det #(.WINDOW(LOC_WINDOW), .SYNC(SYNC_STAGES)) u_loc (
    .bkp_clk(bkp_clk),
    .rst_n  (bkp_rst_n),
    .ref_clk(ref_clk),
    .enable (loc_en_q & ~ext_mode),
    .flag   (loss_flag)
  );

  assign clkout    = sys_clk & ~out_dis_q;
  assign reset_req = loss_flag & loc_en_q & rst_en_q & ~ext_mode;
endmodule

// File: rtl/clkdiv_loc_chk.sv
module clkdiv_loc_chk
  import clkdiv_pkg::*;
(
  input logic             pll_clk,
  input logic             bkp_clk,
  input logic             rst_n,
  input logic             pll_locked,
  input logic             ext_mode,
  input logic             clkout,
  input logic             loss_flag,
  input logic             reset_req,
  input div_code_t        pend_div,
  input div_code_t        div_act,
  input logic [CNT_W-1:0] div_cnt,
  input logic             loc_en_q,
  input logic             rst_en_q,
  input logic             out_dis_q
);
  logic [CNT_W:0] lim;
  assign lim = ((CNT_W+1)'(1) << div_act) - (CNT_W+1)'(1);

  a_r2_cnt_in_range: assert property (@(posedge pll_clk) disable iff (!rst_n)
    ({1'b0, div_cnt} <= lim));

  a_r4_div_frozen_unlocked: assert property (@(posedge pll_clk) disable iff (!rst_n)
    !pll_locked |=> $stable(pend_div));

  a_r5_clkout_off: assert property (@(posedge bkp_clk) disable iff (!rst_n)
    out_dis_q |-> !clkout);

  a_r7_flag_sticky: assert property (@(posedge bkp_clk) disable iff (!rst_n)
    loss_flag |=> loss_flag);

  a_r8_req_cause: assert property (@(posedge pll_clk) disable iff (!rst_n)
    reset_req |-> (loss_flag && loc_en_q && rst_en_q));

  a_r9_ext_blocks_req: assert property (@(posedge pll_clk) disable iff (!rst_n)
    ext_mode |-> !reset_req);
endmodule

bind clkdiv_loc_top clkdiv_loc_chk u_chk (
  .pll_clk   (pll_clk),
  .bkp_clk   (bkp_clk),
  .rst_n     (rst_n),
  .pll_locked(pll_locked),
  .ext_mode  (ext_mode),
  .clkout    (clkout),
  .loss_flag (loss_flag),
  .reset_req (reset_req),
  .pend_div  (pend_div),
  .div_act   (div_act),
  .div_cnt   (div_cnt),
  .loc_en_q  (loc_en_q),
  .rst_en_q  (rst_en_q),
  .out_dis_q (out_dis_q)
);

// File: tb/sim_clkdiv_loc_top.sv
module sim_clkdiv_loc_top;
  localparam int PLL_T    = 10;
  localparam int BKP_T    = 6;
  localparam int REF_HALF = 20;
  localparam int WDOG     = 150000;

  logic pll_clk = 1'b0, bkp_clk = 1'b0, ref_clk = 1'b0;
  logic rst_n, pll_locked, ext_mode, wr_en;
  logic [2:0] wr_div;
  logic wr_loc_en, wr_rst_en, wr_out_dis;
  logic sys_clk, clkout, loss_flag, reset_req;
  bit   ref_run = 1'b1;
  int   n_chk = 0, n_err = 0, cyc = 0;
  bit   done = 1'b0;

  // bench model of the register
  logic [2:0] m_div;

  clkdiv_loc_top u0 (
    .pll_clk(pll_clk), .bkp_clk(bkp_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .pll_locked(pll_locked), .ext_mode(ext_mode), .wr_en(wr_en),
    .wr_div(wr_div), .wr_loc_en(wr_loc_en), .wr_rst_en(wr_rst_en),
    .wr_out_dis(wr_out_dis), .sys_clk(sys_clk), .clkout(clkout),
    .loss_flag(loss_flag), .reset_req(reset_req));

  always #(PLL_T/2) pll_clk = ~pll_clk;
  always #(BKP_T/2) bkp_clk = ~bkp_clk;
  always begin
    #(REF_HALF);
    if (ref_run) ref_clk = ~ref_clk;
  end

  function automatic int exp_gap(input logic [2:0] code);
    return 1 << code;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge pll_clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] d, input logic le, input logic re, input logic od);
    @(negedge pll_clk);
    wr_en = 1'b1; wr_div = d; wr_loc_en = le; wr_rst_en = re; wr_out_dis = od;
    if (pll_locked) m_div = d;
    @(posedge pll_clk); #1;
    wr_en = 1'b0;
  endtask

  // cycles from the current point to the first pulse, and from there to the next
  task automatic pulse_times(output int first, output int gap);
    int n, p0;
    bit seen;
    n = 0; seen = 1'b0; first = -1; gap = -1; p0 = 0;
    while (n < 1000) begin
      @(posedge pll_clk); #1; n++;
      if (sys_clk) begin
        if (seen) begin gap = n - p0; return; end
        seen = 1'b1; p0 = n; first = n;
      end
    end
  endtask

  task automatic wait_bkp(input int k);
    for (int i = 0; i < k; i++) @(posedge bkp_clk);
    #1;
  endtask

  initial begin
    int f, g, seed;
    logic [2:0] c;
    logic lk;
    rst_n = 1'b0; pll_locked = 1'b1; ext_mode = 1'b0; wr_en = 1'b0;
    wr_div = '0; wr_loc_en = 1'b0; wr_rst_en = 1'b0; wr_out_dis = 1'b0;
    m_div = '0;
    seed = $urandom(32'hC10C);
    repeat (5) @(posedge pll_clk);
    #2 rst_n = 1'b1;
    repeat (10) @(posedge pll_clk);

    // R1 reset state
    #1;
    check(loss_flag == 1'b0, "R1 loss_flag", loss_flag, 0);
    check(reset_req == 1'b0, "R1 reset_req", reset_req, 0);
    pulse_times(f, g);
    check(g == 1, "R1 ratio", g, 1);
    @(posedge pll_clk); #1;
    check(clkout == 1'b1, "R1 clkout high phase", clkout, 1);
    @(negedge pll_clk); #1;
    check(clkout == 1'b0, "R1 clkout low phase", clkout, 0);

    // R2 every code, directed
    for (int k = 0; k < 8; k++) begin
      do_write(3'(k), 1'b0, 1'b0, 1'b0);
      pulse_times(f, g);
      check(g == exp_gap(3'(k)), "R2 ratio", g, exp_gap(3'(k)));
    end

    // R3 write inside a /128 period: old period completes, then /1
    pulse_times(f, g);           // ends just after a pulse
    do_write(3'd0, 1'b0, 1'b0, 1'b0);
    pulse_times(f, g);
    check(f == 127, "R3 old period completes", f, 127);
    check(g == 1, "R3 new ratio after pulse", g, 1);

    // R3 shrink and grow in the middle of a /8 period
    do_write(3'd3, 1'b0, 1'b0, 1'b0);
    pulse_times(f, g);
    do_write(3'd5, 1'b0, 1'b0, 1'b0);
    pulse_times(f, g);
    check(f == 7, "R3 old /8 completes", f, 7);
    check(g == 32, "R3 /32 follows", g, 32);

    // R4 write while unlocked keeps ratio but stores other bits
    do_write(3'd2, 1'b0, 1'b0, 1'b0);
    pll_locked = 1'b0;
    do_write(3'd6, 1'b0, 1'b0, 1'b1);
    pll_locked = 1'b1;
    pulse_times(f, g);
    check(g == 4, "R4 ratio unchanged", g, 4);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 16; i++) begin
        @(posedge pll_clk); #1;
        if (clkout) hi++;
      end
      check(hi == 0, "R4 out_dis stored / R5 clkout low", hi, 0);
    end

    // R5 clkout follows sys_clk when enabled
    do_write(3'd1, 1'b0, 1'b0, 1'b0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 32; i++) begin
        @(posedge pll_clk); #1;
        if (clkout !== sys_clk) bad++;
        @(negedge pll_clk); #1;
        if (clkout !== sys_clk) bad++;
      end
      check(bad == 0, "R5 clkout equals sys_clk", bad, 0);
    end

    // R2 and R4 random mix
    for (int it = 0; it < 12; it++) begin
      c  = 3'($urandom % 8);
      lk = ($urandom % 4) != 0;
      pll_locked = lk;
      do_write(c, 1'b0, 1'b0, 1'b0);
      pll_locked = 1'b1;
      pulse_times(f, g);
      pulse_times(f, g);
      check(g == exp_gap(m_div), lk ? "R2 random ratio" : "R4 random unlocked", g, exp_gap(m_div));
    end
    do_write(3'd0, 1'b0, 1'b0, 1'b0);

    // R6 supervisor off: no flag, no request
    do_write(3'd0, 1'b0, 1'b1, 1'b0);
    ref_run = 1'b0;
    wait_bkp(80);
    check(loss_flag == 1'b0, "R6 no flag when disabled", loss_flag, 0);
    check(reset_req == 1'b0, "R6 no request when disabled", reset_req, 0);

    // R9 external mode blocks detection and request
    ext_mode = 1'b1;
    do_write(3'd0, 1'b1, 1'b1, 1'b0);
    wait_bkp(80);
    check(loss_flag == 1'b0, "R9 no flag in ext mode", loss_flag, 0);
    check(reset_req == 1'b0, "R9 no request in ext mode", reset_req, 0);

    // R7 running reference: no false flag
    ref_run = 1'b1;
    do_write(3'd0, 1'b1, 1'b0, 1'b0);
    ext_mode = 1'b0;
    wait_bkp(300);
    check(loss_flag == 1'b0, "R7 no flag while toggling", loss_flag, 0);

    // R7 stop reference: not before window, set after it
    ref_run = 1'b0;
    wait_bkp(8);
    check(loss_flag == 1'b0, "R7 not before window", loss_flag, 0);
    wait_bkp(30);
    check(loss_flag == 1'b1, "R7 flag after window", loss_flag, 1);
    check(reset_req == 1'b0, "R8 no request without reset enable", reset_req, 0);
    ref_run = 1'b1;
    wait_bkp(100);
    check(loss_flag == 1'b1, "R7 flag sticky", loss_flag, 1);

    // R8 reset enable set with flag already up
    do_write(3'd0, 1'b1, 1'b1, 1'b0);
    check(reset_req == 1'b1, "R8 immediate request", reset_req, 1);

    // R6 clearing supervisor enable drops the request
    do_write(3'd0, 1'b0, 1'b1, 1'b0);
    check(reset_req == 1'b0, "R6 request gated by enable", reset_req, 0);

    // R9 ext mode gates request with flag set
    do_write(3'd0, 1'b1, 1'b1, 1'b0);
    check(reset_req == 1'b1, "R8 request restored", reset_req, 1);
    @(negedge pll_clk);
    ext_mode = 1'b1;
    @(posedge pll_clk); #1;
    check(reset_req == 1'b0, "R9 request blocked in ext mode", reset_req, 0);

    finish_run();
  end
endmodule